// File: doc/BRIEF.md
# External Interrupt Entry and Return Sequencer

This block serves the one active-low external interrupt line of a small 8-bit processor core. The line is asynchronous, so it is first brought into the clock domain. Two kinds of source drive it. A brief low-going pulse is caught by an edge latch, so it is not lost if it ends before the core can react. A line held low, typically by several open-drain sources tied together, keeps asking for service for as long as it stays low.

The block holds the interrupt mask bit of the condition-code byte. A request is taken only while that bit is clear, and only when the core reports that an instruction has just finished. On acceptance the block sets the mask and freezes a copy of the core state. It writes that state onto a downward-growing stack through a single memory port. It then reads the 13-bit handler address from the fixed pair at 0x1FFA (upper bits) and 0x1FFB (lower byte), and hands the new state to the core with a one-cycle load strobe.

When the core signals a return from interrupt, the block pops the same five bytes in reverse order. It hands them back with the load strobe, and the mask bit takes the value found in the restored condition-code byte. While a sequence runs, `busy_o` stalls the core.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset the mask output `irq_mask_o` is 1, `busy_o` is 0, no memory access or load strobe is issued, the stack pointer is 0x7F and the edge latch is empty.
- R2: An entry starts only at the clock edge where `insn_done_i` is 1, the block is idle, the mask is 0 and a request is pending. A pending request is a latched edge, or the synchronised line being low.
- R3: The entry writes five bytes in five consecutive cycles, starting the cycle after acceptance: PC[7:0], then {3'b000, PC[12:8]}, then X, then A, then CCR. The write addresses are SP, SP-1, SP-2, SP-3 and SP-4, and SP ends 5 lower.
- R4: On acceptance the mask becomes 1. The stacked CCR carries the previous mask value in bit 3 (0). The CCR handed to the core at entry has bit 3 set and its other bits unchanged.
- R5: After the pushes, the block reads 0x1FFA and then 0x1FFB, one cycle each. In the next cycle `load_o` is 1 for exactly one cycle, with `load_pc_o` = {byte@0x1FFA[4:0], byte@0x1FFB}, and X and A as they were frozen.
- R6: A low pulse that returns high before the instruction boundary is still held and serviced. The latch is cleared on acceptance, so one pulse produces exactly one entry.
- R7: If the line is still low when the mask is cleared again by a return, the next instruction boundary starts another entry.
- R8: A return pops five bytes from SP+1 to SP+5 in ascending order, read as CCR, A, X, PC high and PC low. One cycle later `load_o` presents the restored values, and the mask takes bit 3 of the restored CCR.
- R9: A mask write (`mask_wr_i`) while idle sets the mask to `mask_val_i`. Mask writes and `insn_done_i` have no effect while `busy_o` is 1.
- R10: When a return strobe and an acceptable request arrive in the same cycle, the return is done first. When an acceptance and a mask write arrive in the same cycle, the acceptance wins and the mask ends at 1.
- R11: The line passes through two synchronising flops, so a level that has been low for only one clock edge cannot yet start an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset (power-on or external) |
| ext_req_ni | input | 1 | Asynchronous active-low interrupt line |
| insn_done_i | input | 1 | One-cycle strobe at each instruction boundary |
| rti_i | input | 1 | One-cycle strobe requesting the return pop sequence |
| mask_wr_i | input | 1 | Core write of the mask bit |
| mask_val_i | input | 1 | Value for the mask write |
| pc_i | input | 13 | Current program counter |
| x_i | input | 8 | Current index register |
| a_i | input | 8 | Current accumulator |
| ccr_i | input | 8 | Current condition-code byte (bit 3 ignored, the block owns it) |
| mem_addr_o | output | 13 | Memory address for stack or vector access |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the cycle of the read |
| busy_o | output | 1 | A sequence is running; the core must stall |
| load_o | output | 1 | One-cycle strobe: the core takes the load_* values |
| load_pc_o | output | 13 | Program counter to load |
| load_x_o | output | 8 | Index register to load |
| load_a_o | output | 8 | Accumulator to load |
| load_ccr_o | output | 8 | Condition-code byte to load |
| irq_mask_o | output | 1 | Current interrupt mask bit |

## Verification
The hardest situation to reach from the ports is a collision: a return strobe or a mask write in the same cycle as an acceptable request. Both need the mask already clear and the line held low at that exact boundary. The stimulus first completes a full entry and return with the line still low, so the return restores a clear mask. It then fires `rti_i` together with `insn_done_i`. After that it fires `mask_wr_i` together with `insn_done_i`. A behavioural model with a queue of expected bus operations is compared on every clock, so the order of pushes and pops is checked byte by byte.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int FRAME_BYTES = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_VHI,
        S_VLO,
        S_ENTER,
        S_POP,
        S_RET
    } seq_st_e;

endpackage

// File: rtl/ext_irq_req.sv
module ext_irq_req #(
    parameter int SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_req_ni,
    input  logic clear_i,
    output logic pending_o
);

    typedef struct packed {
        logic [SYNC_N:0] pipe;   // [SYNC_N-1:0] synchroniser, [SYNC_N] edge history
        logic            latch;
    } req_t;

    req_t d, q;
    logic fall;

    always_comb begin
        d      = q;
        fall   = q.pipe[SYNC_N] & ~q.pipe[SYNC_N-1];
        d.pipe = {q.pipe[SYNC_N-1:0], ext_req_ni};
        d.latch = (q.latch & ~clear_i) | fall;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.pipe  <= '1;
            q.latch <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pending_o = q.latch | ~q.pipe[SYNC_N-1];

    // R6: acceptance empties the edge latch unless a new edge arrives with it
    a_r6_latch_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_i && !fall) |=> !q.latch);

endmodule

// File: rtl/ext_irq_seq.sv
module ext_irq_seq
    import ext_irq_pkg::*;
#(
    parameter int                ADDR_W      = 13,
    parameter int                DATA_W      = 8,
    parameter int                I_BIT       = 3,
    parameter logic [ADDR_W-1:0] SP_RESET    = 'h7F,
    parameter logic [ADDR_W-1:0] VEC_HI_ADDR = 'h1FFA
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pending_i,
    input  logic              insn_done_i,
    input  logic              rti_i,
    input  logic              mask_wr_i,
    input  logic              mask_val_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] ccr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              accept_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic              load_o,
    output logic [ADDR_W-1:0] load_pc_o,
    output logic [DATA_W-1:0] load_x_o,
    output logic [DATA_W-1:0] load_a_o,
    output logic [DATA_W-1:0] load_ccr_o,
    output logic              irq_mask_o
);

    localparam int                PCH_W       = ADDR_W - DATA_W;
    localparam int                CNT_W       = $clog2(FRAME_BYTES);
    localparam logic [CNT_W-1:0]  LAST_IDX    = CNT_W'(FRAME_BYTES - 1);
    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = VEC_HI_ADDR + ADDR_W'(1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] sp;
        logic              imask;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] ccr;
    } seq_t;

    seq_t d, q;
    logic [DATA_W-1:0] pch_byte;
    logic [DATA_W-1:0] ccr_out;

    always_comb begin
        d           = q;
        accept_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = q.sp;
        mem_wdata_o = '0;
        load_o      = 1'b0;
        pch_byte    = {{(DATA_W-PCH_W){1'b0}}, q.pc[ADDR_W-1:DATA_W]};
        ccr_out     = q.ccr;

        unique case (q.st)
            S_IDLE: begin
                if (rti_i) begin
                    d.st  = S_POP;
                    d.cnt = '0;
                end else if (insn_done_i && pending_i && !q.imask) begin
                    accept_o      = 1'b1;
                    d.st          = S_PUSH;
                    d.cnt         = '0;
                    d.pc          = pc_i;
                    d.x           = x_i;
                    d.a           = a_i;
                    d.ccr         = ccr_i;
                    d.ccr[I_BIT]  = q.imask;
                    d.imask       = 1'b1;
                end else if (mask_wr_i) begin
                    d.imask = mask_val_i;
                end
            end
            S_PUSH: begin
                mem_we_o = 1'b1;
                case (int'(q.cnt))
                    0:       mem_wdata_o = q.pc[DATA_W-1:0];
                    1:       mem_wdata_o = pch_byte;
                    2:       mem_wdata_o = q.x;
                    3:       mem_wdata_o = q.a;
                    default: mem_wdata_o = q.ccr;
                endcase
                d.sp = q.sp - ADDR_W'(1);
                if (q.cnt == LAST_IDX) begin
                    d.st = S_VHI;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            S_VHI: begin
                mem_re_o                  = 1'b1;
                mem_addr_o                = VEC_HI_ADDR;
                d.pc[ADDR_W-1:DATA_W]     = mem_rdata_i[PCH_W-1:0];
                d.st                      = S_VLO;
            end
            S_VLO: begin
                mem_re_o           = 1'b1;
                mem_addr_o         = VEC_LO_ADDR;
                d.pc[DATA_W-1:0]   = mem_rdata_i;
                d.st               = S_ENTER;
            end
            S_ENTER: begin
                load_o          = 1'b1;
                ccr_out[I_BIT]  = 1'b1;
                d.st            = S_IDLE;
            end
            S_POP: begin
                mem_re_o   = 1'b1;
                mem_addr_o = q.sp + ADDR_W'(1);
                d.sp       = q.sp + ADDR_W'(1);
                case (int'(q.cnt))
                    0:       d.ccr = mem_rdata_i;
                    1:       d.a   = mem_rdata_i;
                    2:       d.x   = mem_rdata_i;
                    3:       d.pc[ADDR_W-1:DATA_W] = mem_rdata_i[PCH_W-1:0];
                    default: d.pc[DATA_W-1:0]      = mem_rdata_i;
                endcase
                if (q.cnt == LAST_IDX) begin
                    d.st = S_RET;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            S_RET: begin
                load_o  = 1'b1;
                d.imask = q.ccr[I_BIT];
                d.st    = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st    <= S_IDLE;
            q.cnt   <= '0;
            q.sp    <= SP_RESET;
            q.imask <= 1'b1;
            q.pc    <= '0;
            q.x     <= '0;
            q.a     <= '0;
            q.ccr   <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != S_IDLE);
    assign load_pc_o  = q.pc;
    assign load_x_o   = q.x;
    assign load_a_o   = q.a;
    assign load_ccr_o = ccr_out;
    assign irq_mask_o = q.imask;

    // R3: consecutive stack writes walk downward one byte at a time
    a_r3_push_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - ADDR_W'(1)));

    // R8: consecutive pops walk upward one byte at a time
    a_r8_pop_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == S_POP && $past(q.st) == S_POP) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

    // R5: the vector high byte is read right after the last push
    a_r5_vector_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_we_o) |-> (mem_re_o && mem_addr_o == VEC_HI_ADDR));

    // R5: the load strobe lasts a single cycle
    a_r5_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> !load_o);

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
    parameter int                ADDR_W      = 13,
    parameter int                DATA_W      = 8,
    parameter int                I_BIT       = 3,
    parameter int                SYNC_N      = 2,
    parameter logic [ADDR_W-1:0] SP_RESET    = 'h7F,
    parameter logic [ADDR_W-1:0] VEC_HI_ADDR = 'h1FFA
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ext_req_ni,
    input  logic              insn_done_i,
    input  logic              rti_i,
    input  logic              mask_wr_i,
    input  logic              mask_val_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] ccr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              load_o,
    output logic [ADDR_W-1:0] load_pc_o,
    output logic [DATA_W-1:0] load_x_o,
    output logic [DATA_W-1:0] load_a_o,
    output logic [DATA_W-1:0] load_ccr_o,
    output logic              irq_mask_o
);

    logic pending;
    logic accept;

    ext_irq_req #(
        .SYNC_N (SYNC_N)
    ) u_req (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ext_req_ni (ext_req_ni),
        .clear_i    (accept),
        .pending_o  (pending)
    );

    ext_irq_seq #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .I_BIT       (I_BIT),
        .SP_RESET    (SP_RESET),
        .VEC_HI_ADDR (VEC_HI_ADDR)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pending_i   (pending),
        .insn_done_i (insn_done_i),
        .rti_i       (rti_i),
        .mask_wr_i   (mask_wr_i),
        .mask_val_i  (mask_val_i),
        .pc_i        (pc_i),
        .x_i         (x_i),
        .a_i         (a_i),
        .ccr_i       (ccr_i),
        .mem_rdata_i (mem_rdata_i),
        .accept_o    (accept),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_wdata_o (mem_wdata_o),
        .busy_o      (busy_o),
        .load_o      (load_o),
        .load_pc_o   (load_pc_o),
        .load_x_o    (load_x_o),
        .load_a_o    (load_a_o),
        .load_ccr_o  (load_ccr_o),
        .irq_mask_o  (irq_mask_o)
    );

    // R2: a stack write sequence only begins after an unmasked boundary
    a_r2_entry_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_o) |-> ($past(insn_done_i) && !$past(irq_mask_o)));

    // R4: the mask is already set when the first stack byte is written
    a_r4_mask_set_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_o) |-> irq_mask_o);

endmodule

// File: tb/ext_irq_unit_tb.sv
module ext_irq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_req_n = 1'b1;
    logic        insn_done = 1'b0;
    logic        rti = 1'b0;
    logic        mask_wr = 1'b0;
    logic        mask_val = 1'b0;
    logic [12:0] pc = '0;
    logic [7:0]  xr = '0;
    logic [7:0]  ar = '0;
    logic [7:0]  ccr = '0;
    logic [12:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, load;
    logic [12:0] load_pc;
    logic [7:0]  load_x, load_a, load_ccr;
    logic        irq_mask;

    localparam logic [7:0] VH = 8'hFA;
    localparam logic [7:0] VL = 8'h3C;

    logic [7:0] mem [0:255];

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int dut_entries = 0;
    logic prev_we = 1'b0;

    always #4 clk = ~clk;

    assign mem_rdata = (mem_addr == 13'h1FFA) ? VH :
                       (mem_addr == 13'h1FFB) ? VL : mem[mem_addr[7:0]];

    ext_irq_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ext_req_ni(ext_req_n), .insn_done_i(insn_done),
        .rti_i(rti), .mask_wr_i(mask_wr), .mask_val_i(mask_val), .pc_i(pc), .x_i(xr),
        .a_i(ar), .ccr_i(ccr), .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .busy_o(busy), .load_o(load),
        .load_pc_o(load_pc), .load_x_o(load_x), .load_a_o(load_a), .load_ccr_o(load_ccr),
        .irq_mask_o(irq_mask)
    );

    // ---------------- reference model ----------------
    typedef struct {
        int    kind;   // 1 write, 2 read, 3 entry load, 4 return load
        int    addr;
        int    data;
        int    lpc, lx, la, lccr;
        string tag;
    } op_t;

    op_t  mq[$];
    logic [2:0] ms = 3'b111;   // ms[0] first flop, ms[1] second, ms[2] history
    logic mlatch = 1'b0;
    logic mmask = 1'b1;
    int   msp = 'h7F;

    function automatic op_t mk(int k, int ad, int dt, string t);
        op_t o;
        o.kind = k; o.addr = ad; o.data = dt; o.tag = t;
        o.lpc = 0; o.lx = 0; o.la = 0; o.lccr = 0;
        return o;
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        if (!rst_n) begin
            mq.delete(); ms = 3'b111; mlatch = 1'b0; mmask = 1'b1; msp = 'h7F;
        end else begin
            logic pend, fall, acc;
            op_t o;
            int  sv_ccr;
            pend = mlatch | ~ms[1];
            fall = ms[2] & ~ms[1];
            acc  = 1'b0;
            if (mq.size() > 0) begin
                o = mq.pop_front();
                if (o.kind == 4) mmask = o.lccr[3];
            end else if (rti) begin
                for (int i = 1; i <= 5; i++) mq.push_back(mk(2, (msp + i) & 'h1FFF, 0, "R8"));
                o = mk(4, 0, 0, "R8");
                o.lccr = mem[(msp + 1) & 'hFF];
                o.la   = mem[(msp + 2) & 'hFF];
                o.lx   = mem[(msp + 3) & 'hFF];
                o.lpc  = ((mem[(msp + 4) & 'hFF] & 'h1F) << 8) | mem[(msp + 5) & 'hFF];
                mq.push_back(o);
                msp = msp + 5;
            end else if (insn_done && pend && !mmask) begin
                acc = 1'b1;
                sv_ccr = (ccr & 'hF7);
                mq.push_back(mk(1, msp,     pc & 'hFF, "R3"));
                mq.push_back(mk(1, msp - 1, (pc >> 8) & 'h1F, "R3"));
                mq.push_back(mk(1, msp - 2, xr, "R3"));
                mq.push_back(mk(1, msp - 3, ar, "R3"));
                mq.push_back(mk(1, msp - 4, sv_ccr, "R4"));
                mq.push_back(mk(2, 'h1FFA, 0, "R5"));
                mq.push_back(mk(2, 'h1FFB, 0, "R5"));
                o = mk(3, 0, 0, "R5");
                o.lpc = ((VH & 'h1F) << 8) | VL;
                o.lx = xr; o.la = ar; o.lccr = sv_ccr | 'h08;
                mq.push_back(o);
                msp = msp - 5;
                mmask = 1'b1;
            end else if (mask_wr) begin
                mmask = mask_val;
            end
            mlatch = (mlatch & ~acc) | fall;
            ms = {ms[1:0], ext_req_n};
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                chk("R4 mask", 32'(irq_mask), 32'(mmask));
                chk("R2 busy", 32'(busy), 32'(mq.size() > 0));
                if (mq.size() > 0) begin
                    chk({mq[0].tag, " write enable"}, 32'(mem_we), 32'(mq[0].kind == 1));
                    chk({mq[0].tag, " read enable"},  32'(mem_re), 32'(mq[0].kind == 2));
                    chk({mq[0].tag, " load strobe"},  32'(load), 32'(mq[0].kind >= 3));
                    if (mq[0].kind <= 2) chk({mq[0].tag, " address"}, 32'(mem_addr), 32'(mq[0].addr & 'h1FFF));
                    if (mq[0].kind == 1) chk({mq[0].tag, " data"}, 32'(mem_wdata), 32'(mq[0].data));
                    if (mq[0].kind >= 3) begin
                        chk({mq[0].tag, " pc"},  32'(load_pc),  32'(mq[0].lpc));
                        chk({mq[0].tag, " x"},   32'(load_x),   32'(mq[0].lx));
                        chk({mq[0].tag, " a"},   32'(load_a),   32'(mq[0].la));
                        chk({mq[0].tag, " ccr"}, 32'(load_ccr), 32'(mq[0].lccr));
                    end
                end else begin
                    chk("R2 idle bus", 32'({mem_we, mem_re, load}), 32'(0));
                end
                if (mem_we && !prev_we) dut_entries++;
                prev_we = mem_we;
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk) insn_done = 1'b1;
        @(negedge clk) insn_done = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic ret();
        @(negedge clk) rti = 1'b1;
        @(negedge clk) rti = 1'b0;
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk("R1 mask after reset", 32'(irq_mask), 32'(1));
        chk("R1 busy after reset", 32'(busy), 32'(0));

        // R2: masked pulse must not enter
        pc = 13'h0A5C; xr = 8'h11; ar = 8'h22; ccr = 8'hC5;
        @(negedge clk) ext_req_n = 1'b0;
        tick(3);
        ext_req_n = 1'b1;
        boundary(); boundary();
        tick(1);
        chk("R2 no entry while masked", 32'(dut_entries), 32'(0));

        // R9: idle mask write clears the mask; R6: held pulse then serviced
        @(negedge clk) begin mask_wr = 1'b1; mask_val = 1'b0; end
        @(negedge clk) mask_wr = 1'b0;
        chk("R9 mask write while idle", 32'(irq_mask), 32'(0));
        boundary();
        wait_idle();
        chk("R6 latched pulse serviced", 32'(dut_entries), 32'(1));

        // R8: return restores cleared mask; R6: no repeat service
        ret();
        chk("R8 mask restored", 32'(irq_mask), 32'(0));
        boundary(); boundary(); tick(2);
        chk("R6 one entry per pulse", 32'(dut_entries), 32'(1));

        // R11: line low for one edge only is not yet visible
        pc = 13'h1234; xr = 8'h5A; ar = 8'hA5; ccr = 8'h1F;
        @(negedge clk) begin ext_req_n = 1'b0; insn_done = 1'b1; end
        @(negedge clk) insn_done = 1'b0;
        chk("R11 no entry before synchroniser settles", 32'(busy), 32'(0));
        tick(2);

        // level entry; R9: writes and boundaries ignored while busy
        boundary();
        @(negedge clk) begin mask_wr = 1'b1; mask_val = 1'b0; insn_done = 1'b1; end
        @(negedge clk) begin mask_wr = 1'b0; insn_done = 1'b0; end
        wait_idle();
        chk("R9 mask write ignored while busy", 32'(irq_mask), 32'(1));
        chk("R4 entry count", 32'(dut_entries), 32'(2));

        // R7: level still low after return retriggers
        ret();
        pc = 13'h0777; xr = 8'h01; ar = 8'hFE; ccr = 8'h20;
        boundary();
        wait_idle();
        chk("R7 retrigger on held level", 32'(dut_entries), 32'(3));
        ret();

        // R10: return wins over acceptance in the same cycle
        @(negedge clk) begin rti = 1'b1; insn_done = 1'b1; end
        @(negedge clk) begin rti = 1'b0; insn_done = 1'b0; end
        chk("R10 return first: no write", 32'(mem_we), 32'(0));
        chk("R10 return first: pop read", 32'(mem_re), 32'(1));
        wait_idle();
        chk("R10 no entry with return", 32'(dut_entries), 32'(3));

        // R10: acceptance wins over a mask write in the same cycle
        @(negedge clk) begin mask_wr = 1'b1; mask_val = 1'b0; end
        @(negedge clk) mask_wr = 1'b0;
        pc = 13'h0F0F; xr = 8'h3C; ar = 8'hC3; ccr = 8'hE2;
        @(negedge clk) begin insn_done = 1'b1; mask_wr = 1'b1; mask_val = 1'b0; end
        @(negedge clk) begin insn_done = 1'b0; mask_wr = 1'b0; end
        wait_idle();
        chk("R10 acceptance beats mask write", 32'(irq_mask), 32'(1));
        chk("R10 entry taken", 32'(dut_entries), 32'(4));

        ext_req_n = 1'b1;
        ret();
        tick(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule